// File: doc/BRIEF.md
# DVMA Translation Control Register File

This block is the software-visible control and status register set for an I/O address translation unit. A processor reaches it over a plain 32-bit register bus: a byte offset, a write strobe, a read strobe, write data and combinational read data. Every access is a full 32-bit word, and the word index is the byte offset shifted right by two. Each register has its own write mask, its own forced-one bits and its own reset value. The mask-ID register does not overwrite on a write. It gathers the written bits by OR.

The block also sits next to the translation engine. It exports two values to that engine: the base of the translated DVMA window, which it works out from the range code in the control register, and the page-table base. The engine reports translation faults back through a single-cycle fault strobe. A fault loads the fault status and fault address registers and raises a level interrupt. The interrupt stays high until software reads or writes either fault register.

Top module: `dvma_regfile`

## Requirements
- R1: After reset, the registers read as follows. Control reads the VERSION_ID parameter. Arbiter enable reads 0x00000008. Fault status reads 0x00800000. Error enable reads 0x00000003. Mask-ID reads 0x23000000. Every other register reads 0. The outputs irq, win_base and ptab_base are all 0.
- R2: A write to the control register (offset 0x0000) keeps only the written bits under 0x0000001D, which are the range code in bits 4:2 and the enable in bit 0. The stored value is that result ORed with VERSION_ID.
- R3: A control write also sets win_base from the written range code c in bits 4:2: win_base = 2^32 - (16 MB << c). Code 0 gives 0xFF000000 and code 7 gives 0x80000000.
- R4: The page-table base register (0x0004) keeps the written bits under 0x07FFFC00 and drives ptab_base with that value. The two flush registers (0x0014 and 0x0018) store all 32 bits written.
- R5: A write to fault status (0x1000) keeps the bits under 0xFF0FFFFF, and bit 23 always reads 1. Fault address (0x1004) stores all 32 bits written.
- R6: A read or a write of offset 0x1000 or 0x1004 drives irq low from the next clock edge, unless a fault arrives in the same cycle.
- R7: A cycle with flt_valid high loads fault status with 0xC0820000, plus bit 18 (0x00040000) when flt_write is 0. It loads fault address with flt_addr with bits 11:0 cleared. It sets irq from the next edge, and irq then stays high until an R6 access.
- R8: When a fault and a software write to either fault register fall in the same cycle, the fault values are stored and irq ends up high.
- R9: Error enable (0x1008) keeps the bits under 0x801F000F, and bit 0 is forced to 1. The four bus configuration registers (0x1010, 0x1014, 0x1018, 0x101C) each keep the bits under 0x00010003, independently of one another.
- R10: Arbiter enable (0x2000) keeps the bits under 0x001F0000, and bit 3 is forced to 1.
- R11: A write to mask-ID (0x3018) ORs the written bits under 0x00FFFFFF into the current contents. No write can clear a bit.
- R12: An offset that maps to no register reads 0, and a write to it changes nothing. Bits 1:0 of the offset are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (14) | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe; used to clear the interrupt |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| flt_valid | input | 1 | Fault report from the translation engine |
| flt_addr | input | 32 | DVMA address that faulted |
| flt_write | input | 1 | 1 when the faulting access was a write |
| irq | output | 1 | Level fault interrupt |
| win_base | output | 32 | Lowest address of the DVMA window |
| ptab_base | output | 32 | Page-table base for the translation engine |

## Verification
A register that is corrupted or a mask that is wrong does not show up on its own. It shows up only on the read of the word that follows the write, so every write is paired with a read-back of the same offset. A stale window base or page-table base appears on win_base or ptab_base one edge after the control or base write. A fault that is dropped, or a clear that is missing, shows up on irq one edge after the strobe or the register access. If a fault loses priority to a software write in the same cycle, the status value read back next differs from the fault encoding.

// File: rtl/dvma_regfile_pkg.sv
package dvma_regfile_pkg;
  localparam int DW     = 32;
  localparam int NUM_SB = 4;

  // select indices
  localparam int S_CTRL = 0;
  localparam int S_PTB  = 1;
  localparam int S_TLBF = 2;
  localparam int S_PGF  = 3;
  localparam int S_FSR  = 4;
  localparam int S_FAR  = 5;
  localparam int S_AER  = 6;
  localparam int S_SB0  = 7;
  localparam int S_ARB  = S_SB0 + NUM_SB;
  localparam int S_MID  = S_ARB + 1;
  localparam int N_SEL  = S_MID + 1;

  localparam logic [31:0] M_CTRL = 32'h0000_001D;
  localparam logic [31:0] M_PTB  = 32'h07FF_FC00;
  localparam logic [31:0] M_FSR  = 32'hFF0F_FFFF;
  localparam logic [31:0] F_FSR  = 32'h0080_0000;
  localparam logic [31:0] M_AER  = 32'h801F_000F;
  localparam logic [31:0] F_AER  = 32'h0000_0001;
  localparam logic [31:0] M_SB   = 32'h0001_0003;
  localparam logic [31:0] M_ARB  = 32'h001F_0000;
  localparam logic [31:0] F_ARB  = 32'h0000_0008;
  localparam logic [31:0] M_MID  = 32'h00FF_FFFF;
  localparam logic [31:0] RST_AER = 32'h0000_0003;
  localparam logic [31:0] RST_MID = 32'h2300_0000;

  // word index (byte offset >> 2) of each selectable register
  function automatic logic [11:0] sel_word(input int i);
    case (i)
      S_CTRL:  return 12'h000;
      S_PTB:   return 12'h001;
      S_TLBF:  return 12'h005;
      S_PGF:   return 12'h006;
      S_FSR:   return 12'h400;
      S_FAR:   return 12'h401;
      S_AER:   return 12'h402;
      S_ARB:   return 12'h800;
      S_MID:   return 12'hC06;
      default: return 12'h404 + 12'(i - S_SB0);
    endcase
  endfunction

  // lowest address of the window for a range code
  function automatic logic [31:0] win_base_of(input logic [2:0] code);
    return 32'd0 - (32'h0100_0000 << code);
  endfunction

  // status word recorded for a translation fault
  function automatic logic [31:0] fault_status_of(input logic is_write);
    return 32'hC082_0000 | (is_write ? 32'h0 : 32'h0004_0000);
  endfunction

  function automatic logic [31:0] page_of(input logic [31:0] a);
    return a & 32'hFFFF_F000;
  endfunction
endpackage

// File: rtl/dvma_addr_decode.sv
module dvma_addr_decode
  import dvma_regfile_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [N_SEL-1:0]  sel
);
  localparam int IDX_W = ADDR_W - 2;

  logic unused_lo;
  assign unused_lo = ^addr[1:0];

  for (genvar i = 0; i < N_SEL; i++) begin : g_sel
    localparam logic [11:0] WORD = sel_word(i);
    assign sel[i] = (addr[ADDR_W-1:2] == WORD[IDX_W-1:0]);
  end

  always_comb begin
    assert ($onehot0(sel)) else $error("a_r12_decode_unique");
  end
endmodule

// File: rtl/dvma_cfg_regs.sv
module dvma_cfg_regs
  import dvma_regfile_pkg::*;
#(
  parameter logic [31:0] VERSION_ID = 32'h4100_0000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [DW-1:0]              wdata,
  input  logic [N_SEL-1:0]           sel,
  output logic [DW-1:0]              ctrl_q,
  output logic [DW-1:0]              ptb_q,
  output logic [DW-1:0]              tlbf_q,
  output logic [DW-1:0]              pgf_q,
  output logic [DW-1:0]              aer_q,
  output logic [NUM_SB-1:0][DW-1:0]  sb_q,
  output logic [DW-1:0]              arb_q,
  output logic [DW-1:0]              mid_q,
  output logic [DW-1:0]              win_base
);
  logic ctrl_we;
  assign ctrl_we = wr & sel[S_CTRL];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= VERSION_ID;
      win_base <= '0;
    end else if (ctrl_we) begin
      ctrl_q   <= (wdata & M_CTRL) | VERSION_ID;
      win_base <= win_base_of(wdata[4:2]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptb_q  <= '0;
      tlbf_q <= '0;
      pgf_q  <= '0;
      aer_q  <= RST_AER;
      arb_q  <= F_ARB;
      mid_q  <= RST_MID;
    end else if (wr) begin
      if (sel[S_PTB])  ptb_q  <= wdata & M_PTB;
      if (sel[S_TLBF]) tlbf_q <= wdata;
      if (sel[S_PGF])  pgf_q  <= wdata;
      if (sel[S_AER])  aer_q  <= (wdata & M_AER) | F_AER;
      if (sel[S_ARB])  arb_q  <= (wdata & M_ARB) | F_ARB;
      if (sel[S_MID])  mid_q  <= mid_q | (wdata & M_MID);
    end
  end

  for (genvar k = 0; k < NUM_SB; k++) begin : g_sb
    always_ff @(posedge clk) begin
      if (!rst_n)                  sb_q[k] <= '0;
      else if (wr && sel[S_SB0+k]) sb_q[k] <= wdata & M_SB;
    end
  end

  a_r11_mid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((mid_q & $past(mid_q)) == $past(mid_q)));
  a_r3_win_shape: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (win_base[23:0] == 24'h0 && win_base[31]));
  a_r3_win_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> $stable(win_base));
  a_r10_arb_forced: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> arb_q[3]);
  a_r9_aer_forced: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> aer_q[0]);
endmodule

// File: rtl/dvma_fault_unit.sv
module dvma_fault_unit
  import dvma_regfile_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] wdata,
  input  logic          sel_fsr,
  input  logic          sel_far,
  input  logic          flt_valid,
  input  logic [DW-1:0] flt_addr,
  input  logic          flt_write,
  output logic [DW-1:0] fsr_q,
  output logic [DW-1:0] far_q,
  output logic          irq_o
);
  logic fault_access;   // software touches either fault register
  logic irq_clr_evt;    // access that actually clears
  assign fault_access = (bus_wr | bus_rd) & (sel_fsr | sel_far);
  assign irq_clr_evt  = fault_access & ~flt_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsr_q <= F_FSR;
      far_q <= '0;
      irq_o <= 1'b0;
    end else if (flt_valid) begin
      fsr_q <= fault_status_of(flt_write);
      far_q <= page_of(flt_addr);
      irq_o <= 1'b1;
    end else begin
      if (bus_wr && sel_fsr) fsr_q <= (wdata & M_FSR) | F_FSR;
      if (bus_wr && sel_far) far_q <= wdata;
      if (irq_clr_evt)       irq_o <= 1'b0;
    end
  end

  a_r6_access_clears: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr_evt |=> !irq_o);
  a_r7_fault_raises: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |=> (irq_o && fsr_q[31] && far_q[11:0] == 12'h0));
  a_r7_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !fault_access) |=> irq_o);
  a_r8_fault_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && bus_wr && sel_fsr) |=> fsr_q[30]);
  a_r5_resv_bit: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> fsr_q[23]);
endmodule

// File: rtl/dvma_regfile.sv
module dvma_regfile
  import dvma_regfile_pkg::*;
#(
  parameter int          ADDR_W     = 14,
  parameter logic [31:0] VERSION_ID = 32'h4100_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              flt_valid,
  input  logic [31:0]       flt_addr,
  input  logic              flt_write,
  output logic              irq,
  output logic [31:0]       win_base,
  output logic [31:0]       ptab_base
);
  logic [N_SEL-1:0]          sel;
  logic [N_SEL-1:0][DW-1:0]  rd_vec;
  logic [NUM_SB-1:0][DW-1:0] sb_q;
  logic [DW-1:0] ctrl_q, ptb_q, tlbf_q, pgf_q, aer_q, arb_q, mid_q, fsr_q, far_q;

  dvma_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  dvma_cfg_regs #(.VERSION_ID(VERSION_ID)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (bus_wr),
    .wdata    (bus_wdata),
    .sel      (sel),
    .ctrl_q   (ctrl_q),
    .ptb_q    (ptb_q),
    .tlbf_q   (tlbf_q),
    .pgf_q    (pgf_q),
    .aer_q    (aer_q),
    .sb_q     (sb_q),
    .arb_q    (arb_q),
    .mid_q    (mid_q),
    .win_base (win_base)
  );

  dvma_fault_unit u_flt (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .wdata     (bus_wdata),
    .sel_fsr   (sel[S_FSR]),
    .sel_far   (sel[S_FAR]),
    .flt_valid (flt_valid),
    .flt_addr  (flt_addr),
    .flt_write (flt_write),
    .fsr_q     (fsr_q),
    .far_q     (far_q),
    .irq_o     (irq)
  );

  assign ptab_base = ptb_q;

  always_comb begin
    rd_vec         = '0;
    rd_vec[S_CTRL] = ctrl_q;
    rd_vec[S_PTB]  = ptb_q;
    rd_vec[S_TLBF] = tlbf_q;
    rd_vec[S_PGF]  = pgf_q;
    rd_vec[S_FSR]  = fsr_q;
    rd_vec[S_FAR]  = far_q;
    rd_vec[S_AER]  = aer_q;
    rd_vec[S_ARB]  = arb_q;
    rd_vec[S_MID]  = mid_q;
    for (int k = 0; k < NUM_SB; k++) rd_vec[S_SB0+k] = sb_q[k];
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < N_SEL; i++)
      if (sel[i]) bus_rdata = bus_rdata | rd_vec[i];
  end

  a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == '0) |-> (bus_rdata == 32'h0));
  a_r4_ptab_export: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel[S_PTB]) |=> ((ptab_base & ~32'h07FF_FC00) == 32'h0));
endmodule

// File: tb/dvma_regfile_bench.sv
module dvma_regfile_bench;
  localparam logic [31:0] VER = 32'h4100_0000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [13:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        flt_valid = 1'b0, flt_write = 1'b0;
  logic [31:0] flt_addr = '0;
  logic        irq;
  logic [31:0] win_base, ptab_base;

  dvma_regfile #(.ADDR_W(14), .VERSION_ID(VER)) u_dvma_regfile (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .flt_valid(flt_valid), .flt_addr(flt_addr), .flt_write(flt_write),
    .irq(irq), .win_base(win_base), .ptab_base(ptab_base)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic note(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares every read against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && bus_rd) begin
      if (exp_q.size() == 0) note("scoreboard-empty", 32'h1, 32'h0);
      else note(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [13:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    cyc();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [13:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_addr = a; bus_rd = 1'b1;
    cyc();
    bus_rd = 1'b0;
  endtask

  task automatic fault(input logic [31:0] a, input logic w);
    flt_addr = a; flt_write = w; flt_valid = 1'b1;
    cyc();
    flt_valid = 1'b0;
  endtask

  function automatic logic [31:0] exp_win(input int code);
    return 32'hFFFF_FFFF << (24 + code);
  endfunction

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R1 reset values
    note("R1 irq", {31'h0, irq}, 32'h0);
    note("R1 win_base", win_base, 32'h0);
    note("R1 ptab_base", ptab_base, 32'h0);
    rd(14'h0000, VER, "R1 ctrl");
    rd(14'h2000, 32'h0000_0008, "R1 arb");
    rd(14'h1000, 32'h0080_0000, "R1 fsr");
    rd(14'h1008, 32'h0000_0003, "R1 aer");
    rd(14'h3018, 32'h2300_0000, "R1 mid");
    rd(14'h1004, 32'h0, "R1 far");
    rd(14'h0014, 32'h0, "R1 tlbf");
    rd(14'h101C, 32'h0, "R1 sb3");

    // R2 control masking
    wr(14'h0000, 32'hFFFF_FFFF);
    rd(14'h0000, 32'h0000_001D | VER, "R2 ctrl all-ones");
    wr(14'h0000, 32'h0000_0002);
    rd(14'h0000, VER, "R2 ctrl bit1 dropped");

    // R3 window base for each code
    for (int c = 0; c < 8; c++) begin
      wr(14'h0000, 32'(c) << 2 | 32'h1);
      note($sformatf("R3 win code %0d", c), win_base, exp_win(c));
    end

    // R4 page table and flushes
    wr(14'h0004, 32'hFFFF_FFFF);
    rd(14'h0004, 32'h07FF_FC00, "R4 ptb");
    note("R4 ptab_base", ptab_base, 32'h07FF_FC00);
    wr(14'h0014, 32'hDEAD_BEEF);
    wr(14'h0018, 32'h1234_5678);
    rd(14'h0014, 32'hDEAD_BEEF, "R4 tlbf");
    rd(14'h0018, 32'h1234_5678, "R4 pgf");

    // R5 fault registers from software
    wr(14'h1000, 32'h0);
    rd(14'h1000, 32'h0080_0000, "R5 fsr zero");
    wr(14'h1000, 32'hFFFF_FFFF);
    rd(14'h1000, 32'hFF8F_FFFF, "R5 fsr ones");
    wr(14'h1004, 32'hCAFE_F00D);
    rd(14'h1004, 32'hCAFE_F00D, "R5 far");

    // R7 read fault, held, then R6 clear by read
    fault(32'h1234_5ABC, 1'b0);
    note("R7 irq set", {31'h0, irq}, 32'h1);
    repeat (3) cyc();
    note("R7 irq held", {31'h0, irq}, 32'h1);
    rd(14'h1000, 32'hC086_0000, "R7 fsr read fault");
    note("R6 irq cleared by read", {31'h0, irq}, 32'h0);
    rd(14'h1004, 32'h1234_5000, "R7 far page");

    // write fault, clear by write to far
    fault(32'h8000_0FFF, 1'b1);
    note("R7 irq set write", {31'h0, irq}, 32'h1);
    wr(14'h1004, 32'h0);
    note("R6 irq cleared by write", {31'h0, irq}, 32'h0);
    rd(14'h1000, 32'hC082_0000, "R7 fsr write fault");

    // R8 fault and software write in same cycle
    bus_addr = 14'h1000; bus_wdata = 32'h0; bus_wr = 1'b1;
    flt_addr = 32'h0000_7123; flt_write = 1'b1; flt_valid = 1'b1;
    cyc();
    bus_wr = 1'b0; flt_valid = 1'b0;
    note("R8 irq high", {31'h0, irq}, 32'h1);
    rd(14'h1000, 32'hC082_0000, "R8 fsr fault wins");
    rd(14'h1004, 32'h0000_7000, "R8 far");

    // R9 error enable and bus configs
    wr(14'h1008, 32'h0);
    rd(14'h1008, 32'h0000_0001, "R9 aer zero");
    wr(14'h1008, 32'hFFFF_FFFF);
    rd(14'h1008, 32'h801F_000F, "R9 aer ones");
    wr(14'h1010, 32'hFFFF_FFFF);
    wr(14'h1014, 32'h0000_0002);
    wr(14'h1018, 32'h0001_0000);
    wr(14'h101C, 32'h0000_0001);
    rd(14'h1010, 32'h0001_0003, "R9 sb0");
    rd(14'h1014, 32'h0000_0002, "R9 sb1");
    rd(14'h1018, 32'h0001_0000, "R9 sb2");
    rd(14'h101C, 32'h0000_0001, "R9 sb3");

    // R10 arbiter enable
    wr(14'h2000, 32'h0);
    rd(14'h2000, 32'h0000_0008, "R10 arb zero");
    wr(14'h2000, 32'hFFFF_FFFF);
    rd(14'h2000, 32'h001F_0008, "R10 arb ones");

    // R11 mask-id accumulation
    wr(14'h3018, 32'h0000_000F);
    rd(14'h3018, 32'h2300_000F, "R11 mid first");
    wr(14'h3018, 32'h0000_00F0);
    rd(14'h3018, 32'h2300_00FF, "R11 mid or");
    wr(14'h3018, 32'hFF00_0000);
    rd(14'h3018, 32'h2300_00FF, "R11 mid no clear");

    // R12 unmapped offsets and low address bits
    wr(14'h0000, 32'h0000_0005);
    wr(14'h0008, 32'hFFFF_FFFF);
    wr(14'h3FFC, 32'hFFFF_FFFF);
    rd(14'h0008, 32'h0, "R12 unmapped 0x8");
    rd(14'h3FFC, 32'h0, "R12 unmapped 0x3ffc");
    rd(14'h0000, 32'h0000_0005 | VER, "R12 ctrl untouched");
    note("R12 win untouched", win_base, exp_win(1));
    rd(14'h0006, 32'h07FF_FC00, "R12 low bits ignored");

    repeat (2) cyc();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule